// File: doc/BRIEF.md
# Serial NOR Flash Operation Controller

This block turns one high-level flash request into the chain of sequencer runs that a serial NOR device needs. It sits above a command sequencer, which owns the wire protocol. The controller hands that sequencer one command at a time: an opcode, an address, a byte count, a direction and an optional one-byte write value. It then waits for the sequencer's completion pulse and reads back the status byte that the sequencer received.

Some operations change the array or the status register. For these the controller first issues write-enable, then the operation itself. After that it keeps reading the status register until the device reports idle. A page program also waits for the device to go idle before it sends write-enable. An ID read is a single run that returns the first byte received. If a sequencer run fails, or the device stays busy for too many reads, the request ends at once with an error code. Requests are accepted only while the controller is idle.

Top module: `flop_op_ctrl`

## Requirements
- R1: `req_ready` is high exactly when the controller is idle, and a request is taken only then. After reset `req_ready`=1, `seq_start`=0 and `err_code`=0. A `req_valid` raised while busy starts no run.
- R2: A sector erase, page program, chip erase or quad enable issues write-enable (0x06), and its main command follows it as the next run.
- R3: After the main command of those operations, status reads (0x05, one byte, read direction) repeat until one reports idle. The request then completes with `err_code`=0.
- R4: The busy flag is status bit `BUSY_BIT` (default 0), and the device is busy when that bit equals `BUSY_LEVEL` (default 1). The other status bits are ignored.
- R5: A page program (`req_op`=2) polls status until idle, then sends write-enable, then sends `PROG_CMD` (0x34). That command carries the full request address, `PAGE_BYTES` (256) bytes and the write direction.
- R6: A sector erase (`req_op`=1) sends `ERASE_CMD` (0x21) with the request address and its low `SECTOR_LG2` (12) bits cleared.
- R7: A quad enable (`req_op`=4) sends 0x01 with one byte of write data, value 0x40.
- R8: An ID read (`req_op`=0) is a single run of 0x9F reading one byte, with no write-enable and no polling. `id_out` then holds the received byte.
- R9: A chip erase (`req_op`=3) sends 0xC7 with no data bytes.
- R10: A run that ends with `seq_err` stops the request at once: no further run, and `err_code`=1.
- R11: If `MAX_POLLS` consecutive status reads in one polling phase all report busy, the request ends after the last of them with `err_code`=2 and no further run.
- R12: Every accepted request produces one single-cycle `done` pulse. `err` pulses with it exactly when the code is nonzero. `err_code` is cleared when a request is accepted and is held from `done` until the next one.
- R13: `req_op` values 5 to 7 complete on the acceptance edge with `err_code`=3 and no sequencer run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; request taken this cycle if valid |
| req_op | input | 3 | 0 ID read, 1 sector erase, 2 page program, 3 chip erase, 4 quad enable |
| req_addr | input | ADDR_W | Target byte address |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle failure pulse, coincident with done |
| err_code | output | 2 | 0 ok, 1 sequencer error, 2 busy timeout, 3 bad op |
| id_out | output | 8 | Last vendor ID byte read |
| seq_start | output | 1 | Start one sequencer run |
| seq_cmd | output | 8 | Command byte of the run |
| seq_addr | output | ADDR_W | Address of the run |
| seq_nbytes | output | NB_W | Data bytes of the run |
| seq_dir | output | 1 | 1 = data to device |
| seq_wval | output | 8 | One-byte write value |
| seq_done | input | 1 | Run finished pulse |
| seq_err | input | 1 | Run failed, valid with seq_done |
| seq_rdata | input | 8 | First byte read by the run, valid with seq_done |

## Verification
The checker assumes the sequencer answers each `seq_start` with exactly one `seq_done` pulse, at least one cycle later, and never signals `seq_done` unprompted. The bench's sequencer model keeps to this with a fixed two-cycle answer. It also sends `req_valid` for single cycles only, and it raises `req_valid` during a busy phase to probe R1. The model returns idle status as 0xFE and busy status as 0x01, so the answer depends only on the configured bit. It counts busy answers separately before and after write-enable, so the pre-program and post-command polling phases are swept on their own.

// File: rtl/flop_pkg.sv
// Shared constants and types for the flash operation controller.
package flop_pkg;
    localparam logic [2:0] OP_RDID   = 3'd0;
    localparam logic [2:0] OP_SERASE = 3'd1;
    localparam logic [2:0] OP_PROG   = 3'd2;
    localparam logic [2:0] OP_CERASE = 3'd3;
    localparam logic [2:0] OP_QUAD   = 3'd4;

    localparam logic [7:0] CMD_WREN   = 8'h06;
    localparam logic [7:0] CMD_RDSR   = 8'h05;
    localparam logic [7:0] CMD_RDID   = 8'h9F;
    localparam logic [7:0] CMD_CERASE = 8'hC7;
    localparam logic [7:0] CMD_WRSR   = 8'h01;
    localparam logic [7:0] QUAD_VAL   = 8'h40;

    typedef enum logic [2:0] {ST_IDLE, ST_PRE, ST_WREN, ST_MAIN, ST_POLL} st_t;
    typedef enum logic [1:0] {EC_OK, EC_SEQ, EC_TIMEOUT, EC_BADOP} ecode_t;
endpackage

// File: rtl/flop_step_fields.sv
// Command field decoder: maps the current step and the latched request
// onto the fields of one sequencer run.
// Assumes: state and request registers are stable while a run is pending.
module flop_step_fields
    import flop_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          PAGE_BYTES = 256,
    parameter int          SECTOR_LG2 = 12,
    parameter logic [7:0]  ERASE_CMD  = 8'h21,
    parameter logic [7:0]  PROG_CMD   = 8'h34,
    localparam int         NB_W       = $clog2(PAGE_BYTES + 1)
) (
    input  st_t               st,
    input  logic [2:0]        op,
    input  logic [ADDR_W-1:0] addr,
    output logic [7:0]        cmd,
    output logic [ADDR_W-1:0] run_addr,
    output logic [NB_W-1:0]   nbytes,
    output logic              dir,
    output logic [7:0]        wval
);
    // Select the command, address, length and data of the current step.
    always_comb begin
        cmd      = 8'h00;
        run_addr = '0;
        nbytes   = '0;
        dir      = 1'b0;
        wval     = 8'h00;
        case (st)
            ST_PRE, ST_POLL: begin
                cmd    = CMD_RDSR;
                nbytes = NB_W'(1);
            end
            ST_WREN: cmd = CMD_WREN;
            ST_MAIN: begin
                case (op)
                    OP_RDID: begin
                        cmd    = CMD_RDID;
                        nbytes = NB_W'(1);
                    end
                    OP_SERASE: begin
                        cmd      = ERASE_CMD;
                        run_addr = {addr[ADDR_W-1:SECTOR_LG2], {SECTOR_LG2{1'b0}}};
                    end
                    OP_PROG: begin
                        cmd      = PROG_CMD;
                        run_addr = addr;
                        nbytes   = NB_W'(PAGE_BYTES);
                        dir      = 1'b1;
                    end
                    OP_CERASE: cmd = CMD_CERASE;
                    OP_QUAD: begin
                        cmd    = CMD_WRSR;
                        nbytes = NB_W'(1);
                        dir    = 1'b1;
                        wval   = QUAD_VAL;
                    end
                    default: cmd = 8'h00;
                endcase
            end
            default: cmd = 8'h00;
        endcase
    end
endmodule

// File: rtl/flop_poll_track.sv
// Busy evaluation and poll budget: decides whether a returned status bit
// means busy, and counts consecutive busy reads within one polling phase.
// Assumes: 'active' drops between polling phases so the count restarts.
module flop_poll_track #(
    parameter int   MAX_POLLS  = 1024,
    parameter logic BUSY_LEVEL = 1'b1,
    localparam int  CNT_W      = $clog2(MAX_POLLS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic sample,
    input  logic flag_bit,
    output logic busy,
    output logic expire
);
    logic [CNT_W-1:0] cnt;

    // Polarity variant chosen at elaboration.
    generate
        if (BUSY_LEVEL) begin : g_high_busy
            assign busy = flag_bit;
        end else begin : g_low_busy
            assign busy = ~flag_bit;
        end
    endgenerate

    // This busy read would be the last one the budget allows.
    assign expire = busy && (cnt == CNT_W'(MAX_POLLS - 1));

    // Count busy reads in the current phase; restart outside polling.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt <= '0;
        end else if (sample && busy && !expire) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/flop_op_ctrl.sv
// Flash operation controller: runs write-enable, the main command and
// status polling as a chain of sequencer runs for one request.
// Assumes: one seq_done per seq_start, arriving at least a cycle later;
// seq_err and seq_rdata are valid with seq_done.
module flop_op_ctrl
    import flop_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          PAGE_BYTES = 256,
    parameter int          SECTOR_LG2 = 12,
    parameter int          MAX_POLLS  = 1024,
    parameter int          BUSY_BIT   = 0,
    parameter logic        BUSY_LEVEL = 1'b1,
    parameter logic [7:0]  ERASE_CMD  = 8'h21,
    parameter logic [7:0]  PROG_CMD   = 8'h34,
    localparam int         NB_W       = $clog2(PAGE_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              done,
    output logic              err,
    output logic [1:0]        err_code,
    output logic [7:0]        id_out,
    output logic              seq_start,
    output logic [7:0]        seq_cmd,
    output logic [ADDR_W-1:0] seq_addr,
    output logic [NB_W-1:0]   seq_nbytes,
    output logic              seq_dir,
    output logic [7:0]        seq_wval,
    input  logic              seq_done,
    input  logic              seq_err,
    input  logic [7:0]        seq_rdata
);
    st_t               st, st_n;
    logic              pend, pend_n;
    logic              fin, grab_id;
    ecode_t            fin_code, code_q;
    logic [2:0]        op_q;
    logic [ADDR_W-1:0] addr_q;
    logic              busy, expire, polling;

    assign req_ready = (st == ST_IDLE);
    assign seq_start = pend;
    assign err_code  = code_q;
    assign polling   = (st == ST_PRE) || (st == ST_POLL);

    flop_poll_track #(.MAX_POLLS(MAX_POLLS), .BUSY_LEVEL(BUSY_LEVEL)) u_poll (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (polling),
        .sample   (seq_done && !seq_err),
        .flag_bit (seq_rdata[BUSY_BIT]),
        .busy     (busy),
        .expire   (expire)
    );

    flop_step_fields #(
        .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .SECTOR_LG2(SECTOR_LG2),
        .ERASE_CMD(ERASE_CMD), .PROG_CMD(PROG_CMD)
    ) u_fields (
        .st       (st),
        .op       (op_q),
        .addr     (addr_q),
        .cmd      (seq_cmd),
        .run_addr (seq_addr),
        .nbytes   (seq_nbytes),
        .dir      (seq_dir),
        .wval     (seq_wval)
    );

    // Step sequencing: pick the next step, or finish with a result code.
    always_comb begin
        st_n     = st;
        pend_n   = 1'b0;
        fin      = 1'b0;
        fin_code = EC_OK;
        grab_id  = 1'b0;
        if (st == ST_IDLE) begin
            if (req_valid) begin
                case (req_op)
                    OP_RDID: begin st_n = ST_MAIN; pend_n = 1'b1; end
                    OP_PROG: begin st_n = ST_PRE;  pend_n = 1'b1; end
                    OP_SERASE, OP_CERASE, OP_QUAD: begin
                        st_n = ST_WREN; pend_n = 1'b1;
                    end
                    default: begin fin = 1'b1; fin_code = EC_BADOP; end
                endcase
            end
        end else if (seq_done) begin
            if (seq_err) begin
                fin = 1'b1; fin_code = EC_SEQ;
            end else begin
                case (st)
                    ST_PRE: begin
                        if (!busy) begin st_n = ST_WREN; pend_n = 1'b1; end
                        else if (expire) begin fin = 1'b1; fin_code = EC_TIMEOUT; end
                        else pend_n = 1'b1;
                    end
                    ST_WREN: begin st_n = ST_MAIN; pend_n = 1'b1; end
                    ST_MAIN: begin
                        if (op_q == OP_RDID) begin grab_id = 1'b1; fin = 1'b1; end
                        else begin st_n = ST_POLL; pend_n = 1'b1; end
                    end
                    ST_POLL: begin
                        if (!busy) fin = 1'b1;
                        else if (expire) begin fin = 1'b1; fin_code = EC_TIMEOUT; end
                        else pend_n = 1'b1;
                    end
                    default: fin = 1'b1;
                endcase
            end
        end
        if (fin) st_n = ST_IDLE;
    end

    // State, request latch, result pulses and held outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            pend   <= 1'b0;
            done   <= 1'b0;
            err    <= 1'b0;
            code_q <= EC_OK;
            op_q   <= '0;
            addr_q <= '0;
            id_out <= 8'h00;
        end else begin
            st   <= st_n;
            pend <= pend_n;
            done <= fin;
            err  <= fin && (fin_code != EC_OK);
            if (fin) code_q <= fin_code;
            else if (req_ready && req_valid) code_q <= EC_OK;
            if (req_ready && req_valid) begin
                op_q   <= req_op;
                addr_q <= req_addr;
            end
            if (grab_id) id_out <= seq_rdata;
        end
    end
endmodule

// File: rtl/flop_op_ctrl_chk.sv
// Property checker for the flash operation controller, bound to the top.
// Assumes the sequencer answers each start with one done pulse.
module flop_op_ctrl_chk
    import flop_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          PAGE_BYTES = 256,
    parameter int          SECTOR_LG2 = 12,
    parameter logic [7:0]  ERASE_CMD  = 8'h21,
    parameter logic [7:0]  PROG_CMD   = 8'h34,
    localparam int         NB_W       = $clog2(PAGE_BYTES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              done,
    input logic              err,
    input logic [1:0]        err_code,
    input logic              seq_start,
    input logic [7:0]        seq_cmd,
    input logic [ADDR_W-1:0] seq_addr,
    input logic [NB_W-1:0]   seq_nbytes,
    input logic              seq_dir,
    input logic [7:0]        seq_wval,
    input logic              seq_done
);
    logic outstanding;

    // Track whether a sequencer run is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) outstanding <= 1'b0;
        else if (seq_start) outstanding <= 1'b1;
        else if (seq_done) outstanding <= 1'b0;
    end

    a_r1_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |-> !req_ready);
    a_r1_single_run: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |-> !outstanding);
    a_r1_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r12_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && err_code != 2'd0));
    a_r12_code_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> $stable(err_code));
    a_r6_sector_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_start && seq_cmd == ERASE_CMD) |-> (seq_addr[SECTOR_LG2-1:0] == '0));
    a_r5_full_page: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_start && seq_cmd == PROG_CMD) |-> (seq_nbytes == NB_W'(PAGE_BYTES) && seq_dir));
    a_r7_quad_value: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_start && seq_cmd == CMD_WRSR) |-> (seq_wval == QUAD_VAL && seq_dir && seq_nbytes == NB_W'(1)));
    a_r8_id_one_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_start && seq_cmd == CMD_RDID) |-> (seq_nbytes == NB_W'(1) && !seq_dir));
endmodule

bind flop_op_ctrl flop_op_ctrl_chk #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .SECTOR_LG2(SECTOR_LG2),
    .ERASE_CMD(ERASE_CMD), .PROG_CMD(PROG_CMD)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .done(done), .err(err), .err_code(err_code), .seq_start(seq_start),
    .seq_cmd(seq_cmd), .seq_addr(seq_addr), .seq_nbytes(seq_nbytes),
    .seq_dir(seq_dir), .seq_wval(seq_wval), .seq_done(seq_done)
);

// File: tb/test_flop_op_ctrl.sv
`timescale 1ns/1ps
module test_flop_op_ctrl;
    localparam int MAXP = 4;
    localparam int NBW  = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic req_valid = 1'b0, req_ready;
    logic [2:0] req_op = '0;
    logic [31:0] req_addr = '0;
    logic done, err;
    logic [1:0] err_code;
    logic [7:0] id_out;
    logic seq_start, seq_dir;
    logic [7:0] seq_cmd, seq_wval;
    logic [31:0] seq_addr;
    logic [NBW-1:0] seq_nbytes;
    logic seq_done = 1'b0, seq_err = 1'b0;
    logic [7:0] seq_rdata = 8'h00;

    flop_op_ctrl #(.MAX_POLLS(MAXP)) i_flop_op_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .done(done), .err(err),
        .err_code(err_code), .id_out(id_out), .seq_start(seq_start),
        .seq_cmd(seq_cmd), .seq_addr(seq_addr), .seq_nbytes(seq_nbytes),
        .seq_dir(seq_dir), .seq_wval(seq_wval), .seq_done(seq_done),
        .seq_err(seq_err), .seq_rdata(seq_rdata)
    );

    int tests = 0, fails = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Sequencer model: answers two negedges after a start.
    int m_runs = 0, m_pre = 0, m_post = 0, m_err_at = -1;
    bit m_wren = 0;
    int timer = 0, cur_idx = 0;
    logic [7:0] cur_cmd = 8'h00;
    logic [7:0]  log_cmd  [0:31];
    logic [31:0] log_addr [0:31];
    logic [8:0]  log_nb   [0:31];
    logic        log_dir  [0:31];
    logic [7:0]  log_wval [0:31];
    int done_cnt = 0, err_cnt = 0;

    always @(negedge clk) begin
        seq_done = 1'b0;
        seq_err  = 1'b0;
        if (done) done_cnt++;
        if (err)  err_cnt++;
        if (seq_start) begin
            if (m_runs < 32) begin
                log_cmd[m_runs]  = seq_cmd;
                log_addr[m_runs] = seq_addr;
                log_nb[m_runs]   = seq_nbytes;
                log_dir[m_runs]  = seq_dir;
                log_wval[m_runs] = seq_wval;
            end
            if (seq_cmd == 8'h06) m_wren = 1;
            cur_cmd = seq_cmd;
            cur_idx = m_runs;
            m_runs++;
            timer = 2;
        end else if (timer > 0) begin
            timer--;
            if (timer == 0) begin
                seq_done = 1'b1;
                seq_err  = (cur_idx == m_err_at);
                seq_rdata = 8'h00;
                if (cur_cmd == 8'h9F) seq_rdata = 8'hC2;
                if (cur_cmd == 8'h05) begin
                    // R4: only bit 0 carries busy; idle keeps other bits set
                    if (!m_wren) begin
                        seq_rdata = (m_pre > 0) ? 8'h01 : 8'hFE;
                        if (m_pre > 0) m_pre--;
                    end else begin
                        seq_rdata = (m_post > 0) ? 8'h01 : 8'hFE;
                        if (m_post > 0) m_post--;
                    end
                end
            end
        end
    end

    // Expected run list computed from the requirements.
    logic [7:0] exp_cmd [0:31];
    int exp_n, exp_code;

    task automatic push(input logic [7:0] c);
        exp_cmd[exp_n] = c;
        exp_n++;
    endtask

    task automatic add_polls(input int b, output bit to);
        int reps;
        reps = (b >= MAXP) ? MAXP : b + 1;
        for (int i = 0; i < reps; i++) push(8'h05);
        to = (b >= MAXP);
    endtask

    task automatic build(input int op, input int pre, input int post);
        bit to;
        exp_n = 0; exp_code = 0; to = 0;
        case (op)
            0: push(8'h9F);
            1: begin push(8'h06); push(8'h21); add_polls(post, to); end
            2: begin
                add_polls(pre, to);
                if (!to) begin push(8'h06); push(8'h34); add_polls(post, to); end
            end
            3: begin push(8'h06); push(8'hC7); add_polls(post, to); end
            4: begin push(8'h06); push(8'h01); add_polls(post, to); end
            default: exp_code = 3;
        endcase
        if (to) exp_code = 2;
    endtask

    function automatic string op_tag(input int op);
        case (op)
            0: return "R8";
            1: return "R6";
            2: return "R5";
            3: return "R9";
            4: return "R7";
            default: return "R13";
        endcase
    endfunction

    task automatic run_case(input int op, input logic [31:0] addr, input int pre,
                            input int post, input int err_at, input bit poke);
        int w;
        string tg;
        build(op, pre, post);
        if (err_at >= 0 && err_at < exp_n) begin exp_n = err_at + 1; exp_code = 1; end
        tg = (exp_code == 1) ? "R10" : (exp_code == 2) ? "R11" : op_tag(op);
        @(negedge clk);
        m_runs = 0; m_pre = pre; m_post = post; m_err_at = err_at; m_wren = 0;
        done_cnt = 0; err_cnt = 0;
        req_valid = 1'b1; req_op = 3'(op); req_addr = addr;
        @(negedge clk);
        req_valid = 1'b0;
        if (exp_code != 3) begin
            check(!req_ready, "R1 busy after accept", req_ready, 0);
            check(err_code == 0, "R12 code cleared on accept", err_code, 0);
        end
        w = 0;
        while (done_cnt == 0 && w < 2000) begin
            if (poke && w == 3) begin req_valid = 1'b1; req_op = 3'd0; end
            if (poke && w == 4) req_valid = 1'b0;
            @(negedge clk);
            w++;
        end
        if (w >= 2000) check(0, "watchdog no done", w, 0);
        repeat (4) @(negedge clk);
        check(m_runs == exp_n, {tg, " run count"}, m_runs, exp_n);
        for (int i = 0; i < exp_n && i < 32; i++) begin
            if (exp_cmd[i] == 8'h06)      check(log_cmd[i] == 8'h06, "R2 write-enable order", log_cmd[i], 8'h06);
            else if (exp_cmd[i] == 8'h05) check(log_cmd[i] == 8'h05, "R3 R4 status poll", log_cmd[i], 8'h05);
            else                          check(log_cmd[i] == exp_cmd[i], {tg, " main cmd"}, log_cmd[i], exp_cmd[i]);
            if (log_cmd[i] == 8'h05)
                check(log_nb[i] == 1 && !log_dir[i], "R3 poll one byte read", log_nb[i], 1);
        end
        check(err_code == 2'(exp_code), {tg, " err_code"}, err_code, exp_code);
        check(done_cnt == 1, "R12 one done pulse", done_cnt, 1);
        check(err_cnt == ((exp_code != 0) ? 1 : 0), "R12 err pulse", err_cnt, (exp_code != 0));
        check(req_ready, "R1 idle after done", req_ready, 1);
        for (int i = 0; i < exp_n && i < 32; i++) begin
            if (exp_cmd[i] == 8'h21)
                check(log_addr[i] == {addr[31:12], 12'h000}, "R6 aligned address", log_addr[i], {addr[31:12], 12'h000});
            if (exp_cmd[i] == 8'h34) begin
                check(log_nb[i] == 256 && log_dir[i], "R5 page length", log_nb[i], 256);
                check(log_addr[i] == addr, "R5 address", log_addr[i], addr);
            end
            if (exp_cmd[i] == 8'h01)
                check(log_wval[i] == 8'h40 && log_nb[i] == 1 && log_dir[i], "R7 quad value", log_wval[i], 8'h40);
            if (exp_cmd[i] == 8'hC7)
                check(log_nb[i] == 0, "R9 no data", log_nb[i], 0);
            if (exp_cmd[i] == 8'h9F)
                check(log_nb[i] == 1 && !log_dir[i], "R8 one byte read", log_nb[i], 1);
        end
        if (op == 0 && exp_code == 0) check(id_out == 8'hC2, "R8 vendor id", id_out, 8'hC2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog global timeout");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready == 1, "R1 reset ready", req_ready, 1);
        check(seq_start == 0, "R1 reset no start", seq_start, 0);
        check(err_code == 0, "R1 reset code", err_code, 0);
        check(done == 0, "R12 reset done", done, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Plain operations and bad op codes (R13).
        for (int op = 0; op < 8; op++) run_case(op, 32'h1234_5ABC, 0, 0, -1, 0);
        // Busy sweep after the main command, including timeout (R3, R11).
        for (int op = 1; op < 5; op++)
            for (int b = 0; b <= MAXP; b++) run_case(op, 32'h00AB_CFFF + 32'(b), 0, b, -1, 0);
        // Page program: both polling phases swept (R5, R11).
        for (int p = 0; p <= MAXP; p++)
            for (int q = 0; q <= MAXP; q++) run_case(2, 32'h0004_0100 + 32'(p * 16 + q), p, q, -1, 0);
        // Error injected at every run position (R10).
        for (int op = 0; op < 5; op++)
            for (int k = 0; k < 7; k++) begin
                build(op, 1, 1);
                if (k < exp_n) run_case(op, 32'hFFFF_F001, 1, 1, k, 0);
            end
        // Request while busy has no effect (R1).
        run_case(1, 32'h0000_3456, 0, 3, -1, 1);
        // Timeout code held while idle (R12).
        run_case(3, 32'h0, 0, MAXP, -1, 0);
        repeat (10) @(negedge clk);
        check(err_code == 2, "R12 code held while idle", err_code, 2);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule